// File: doc/BRIEF.md
# Channel I/O Initiation Sequencer

This block is the control sequencer that carries out the two channel I/O instructions of a processor: start-device and halt-device. A start request brings a channel number, a device number, the condition code already worked out for that channel and device, a burst-mode select and a block-address flag. The sequencer settles the condition code first. Code 0 starts the fetch sequence. Code 1 stores the standard device byte and ends. Codes 2 and 3 are rejected at once.

For code 0 the sequencer reads the channel address word from the fixed low-memory slot at byte address 72. In burst mode, when the block flag is set, it also reads the block address from byte address 76. It then reads the command word from the address held in the low bits of the address word. In burst mode these words land in the multiplexor channel registers. Otherwise they are written to the subchannel storage of the addressed device. After the last word is loaded, the command goes to the device with no check of its legality.

A halt request needs supervisor state, which means the mode bit is 0. The sequencer asserts termination to the device and stalls until the device acknowledges it. It then raises a channel interrupt. If the mode bit is 1, the halt ends at once with a privilege fault.

States are named as follows:
- S_IDLE accepts a request.
- From S_IDLE the sequencer goes to one of these:
  - S_RD_REQ, for a start with code 0.
  - S_STORE, for a start with code 1.
  - S_REJECT, for a start with code 2 or 3.
  - S_HALT, for a halt with mode bit 0.
  - S_PRIV, for a halt with mode bit 1.
- S_RD_REQ goes to S_RD_WAIT when the memory takes the address.
- S_RD_WAIT goes back to S_RD_REQ for the next word, or to S_ISSUE after the command word.
- S_HALT goes to S_HALT_IRQ on acknowledge.
- S_ISSUE, S_STORE, S_REJECT, S_PRIV and S_HALT_IRQ each last one cycle and return to S_IDLE.

Top module: `chio_init_seq`

## Requirements
- R1: After reset, busy, done, rd_valid, cmd_valid, sts_wr_en, sub_wr_en, halt_req, chan_irq and priv_fault are 0, and the three multiplexor registers read 0.
- R2: For a burst-mode start with code 0 (req_burst=1), the reads run in this order:
  - the address word from byte address 72;
  - then, only when req_blk=1, the block address from byte address 76;
  - then the command word from the address in bits [15:0] of the address word.

  mx_caw and mx_ccw take the words read; mx_cba changes only when req_blk=1.
- R3: For a subchannel-mode start with code 0 (req_burst=0), req_blk is ignored and two reads are made: address 72, then the command-word pointer. Each word is written on the subchannel port in the cycle its data returns, with sub_wr_sel=0 for the address word and 1 for the command word, and with the request's device number. The multiplexor registers keep their values.
- R4: A start with code 0 ends with a one-cycle cmd_valid that carries the command word, the channel number and the device number. done is high in that cycle with result_cc=0.
- R5: A start with code 1 makes no memory read and no command. It gives one cycle of sts_wr_en, carrying the channel number and the dev_status value sampled when the request was taken, together with done and result_cc=1.
- R6: A start with code 2 or 3 gives done in the cycle after it is taken, with result_cc equal to the code. There is no read, no status store and no command.
- R7: A halt with mode_bit=0 holds halt_req (with channel and device) until halt_ack is seen, and makes no memory read. In the cycle after the acknowledge, chan_irq is high with irq_chan set to the channel, together with done.
- R8: A halt with mode_bit=1 gives priv_fault and done in the cycle after it is taken, and never asserts halt_req.
- R9: While rd_valid is high and rd_ready is low, rd_valid stays high and rd_addr stays stable. After an address is taken, no new address is presented until rd_rvalid returns the data.
- R10: busy is high from the cycle after a request is taken through the done cycle, and low after it. A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Instruction request, taken when idle |
| req_halt | input | 1 | 1 = halt-device, 0 = start-device |
| req_chan | input | CH_W | Channel number |
| req_dev | input | DEV_W | Device number |
| req_cc | input | 2 | Condition code for the start |
| req_burst | input | 1 | Burst mode select |
| req_blk | input | 1 | Block address present flag |
| mode_bit | input | 1 | 0 = supervisor, halt permitted |
| dev_status | input | STS_W | Standard device byte |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Instruction ends this cycle |
| result_cc | output | 2 | Final condition code, valid with done |
| priv_fault | output | 1 | Halt refused in problem state |
| rd_valid | output | 1 | Memory read address valid |
| rd_addr | output | AW | Memory read byte address |
| rd_ready | input | 1 | Memory takes the address |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | DW | Read data |
| sub_wr_en | output | 1 | Subchannel storage write |
| sub_wr_dev | output | DEV_W | Subchannel device index |
| sub_wr_sel | output | 1 | 0 = address word, 1 = command word |
| sub_wr_data | output | DW | Subchannel write data |
| mx_caw | output | DW | Multiplexor channel address register |
| mx_cba | output | DW | Multiplexor channel block address register |
| mx_ccw | output | DW | Multiplexor channel command register |
| sts_wr_en | output | 1 | Store standard device byte |
| sts_wr_chan | output | CH_W | Channel for the status store |
| sts_wr_byte | output | STS_W | Status byte stored |
| cmd_valid | output | 1 | Command issued to the device |
| cmd_chan | output | CH_W | Command channel |
| cmd_dev | output | DEV_W | Command device |
| cmd_word | output | DW | Command word |
| halt_req | output | 1 | Termination request to device control |
| halt_chan | output | CH_W | Halt channel |
| halt_dev | output | DEV_W | Halt device |
| halt_ack | input | 1 | Device control accepts termination |
| chan_irq | output | 1 | Channel interrupt |
| irq_chan | output | CH_W | Interrupting channel |

## Verification
The assertions watch the cycle-level rules on every cycle:
- the read address is held while it waits and only one read is open at a time;
- codes 1, 2 and 3 and refused halts end in one cycle;
- the halt stalls until acknowledge and the interrupt follows it;
- busy is held until done.

Only the bench scenarios can show which addresses are read, in which order, and which words reach the multiplexor registers, the subchannel port and the command output. The bench checks this for every mix of burst mode, block flag, ready delay and read latency. It also derives the busy length arithmetically from those delays and checks it, and it shows that a request arriving mid-instruction is dropped.

// File: rtl/chio_pkg.sv
package chio_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_REQ,
        S_RD_WAIT,
        S_ISSUE,
        S_STORE,
        S_REJECT,
        S_PRIV,
        S_HALT,
        S_HALT_IRQ
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_CAW,
        PH_CBA,
        PH_CCW
    } fetch_phase_t;

endpackage

// File: rtl/chio_addr_gen.sv
module chio_addr_gen
    import chio_pkg::*;
#(
    parameter int AW         = 16,
    parameter int BASE_ADDR  = 72,
    parameter int WORD_BYTES = 4
) (
    input  fetch_phase_t    phase,
    input  logic [AW-1:0]   ccw_ptr,
    output logic [AW-1:0]   addr
);
    localparam logic [AW-1:0] CAW_SLOT = AW'(BASE_ADDR);
    localparam logic [AW-1:0] CBA_SLOT = AW'(BASE_ADDR + WORD_BYTES);

    always_comb begin
        unique case (phase)
            PH_CAW:  addr = CAW_SLOT;
            PH_CBA:  addr = CBA_SLOT;
            PH_CCW:  addr = ccw_ptr;
            default: addr = CAW_SLOT;
        endcase
    end
endmodule

// File: rtl/chio_word_bank.sv
module chio_word_bank
    import chio_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  fetch_phase_t    phase,
    input  logic            to_mx,
    input  logic [DW-1:0]   data,
    output logic [AW-1:0]   ccw_ptr,
    output logic [DW-1:0]   ccw_q,
    output logic [DW-1:0]   mx_caw,
    output logic [DW-1:0]   mx_cba,
    output logic [DW-1:0]   mx_ccw
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccw_ptr <= '0;
            ccw_q   <= '0;
            mx_caw  <= '0;
            mx_cba  <= '0;
            mx_ccw  <= '0;
        end else if (cap_en) begin
            unique case (phase)
                PH_CAW: begin
                    ccw_ptr <= data[AW-1:0];
                    if (to_mx) mx_caw <= data;
                end
                PH_CBA: begin
                    if (to_mx) mx_cba <= data;
                end
                PH_CCW: begin
                    ccw_q <= data;
                    if (to_mx) mx_ccw <= data;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/chio_init_seq.sv
module chio_init_seq
    import chio_pkg::*;
#(
    parameter int CH_W       = 4,
    parameter int DEV_W      = 8,
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int STS_W      = 8,
    parameter int BASE_ADDR  = 72,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_halt,
    input  logic [CH_W-1:0]   req_chan,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [1:0]        req_cc,
    input  logic              req_burst,
    input  logic              req_blk,
    input  logic              mode_bit,
    input  logic [STS_W-1:0]  dev_status,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result_cc,
    output logic              priv_fault,
    output logic              rd_valid,
    output logic [AW-1:0]     rd_addr,
    input  logic              rd_ready,
    input  logic              rd_rvalid,
    input  logic [DW-1:0]     rd_rdata,
    output logic              sub_wr_en,
    output logic [DEV_W-1:0]  sub_wr_dev,
    output logic              sub_wr_sel,
    output logic [DW-1:0]     sub_wr_data,
    output logic [DW-1:0]     mx_caw,
    output logic [DW-1:0]     mx_cba,
    output logic [DW-1:0]     mx_ccw,
    output logic              sts_wr_en,
    output logic [CH_W-1:0]   sts_wr_chan,
    output logic [STS_W-1:0]  sts_wr_byte,
    output logic              cmd_valid,
    output logic [CH_W-1:0]   cmd_chan,
    output logic [DEV_W-1:0]  cmd_dev,
    output logic [DW-1:0]     cmd_word,
    output logic              halt_req,
    output logic [CH_W-1:0]   halt_chan,
    output logic [DEV_W-1:0]  halt_dev,
    input  logic              halt_ack,
    output logic              chan_irq,
    output logic [CH_W-1:0]   irq_chan
);
    seq_state_t    state, state_n;
    fetch_phase_t  phase, phase_n;

    logic [CH_W-1:0]  chan_q;
    logic [DEV_W-1:0] dev_q;
    logic [1:0]       cc_q;
    logic             burst_q;
    logic             blk_q;
    logic [STS_W-1:0] sts_q;

    logic             accept;
    logic             cap_en;
    logic [AW-1:0]    ccw_ptr;
    logic [DW-1:0]    ccw_q;

    assign accept = req_valid && (state == S_IDLE);
    assign cap_en = (state == S_RD_WAIT) && rd_rvalid;

    // request fields are latched once, at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q  <= '0;
            dev_q   <= '0;
            cc_q    <= '0;
            burst_q <= 1'b0;
            blk_q   <= 1'b0;
            sts_q   <= '0;
        end else if (accept) begin
            chan_q  <= req_chan;
            dev_q   <= req_dev;
            cc_q    <= req_cc;
            burst_q <= req_burst;
            blk_q   <= req_blk;
            sts_q   <= dev_status;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            phase <= PH_CAW;
        end else begin
            state <= state_n;
            phase <= phase_n;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        phase_n = phase;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    phase_n = PH_CAW;
                    if (req_halt)
                        state_n = mode_bit ? S_PRIV : S_HALT;
                    else if (req_cc == 2'd0)
                        state_n = S_RD_REQ;
                    else if (req_cc == 2'd1)
                        state_n = S_STORE;
                    else
                        state_n = S_REJECT;
                end
            end
            S_RD_REQ: begin
                if (rd_ready) state_n = S_RD_WAIT;
            end
            S_RD_WAIT: begin
                if (rd_rvalid) begin
                    unique case (phase)
                        PH_CAW: begin
                            phase_n = (burst_q && blk_q) ? PH_CBA : PH_CCW;
                            state_n = S_RD_REQ;
                        end
                        PH_CBA: begin
                            phase_n = PH_CCW;
                            state_n = S_RD_REQ;
                        end
                        default: state_n = S_ISSUE;
                    endcase
                end
            end
            S_HALT: begin
                if (halt_ack) state_n = S_HALT_IRQ;
            end
            S_ISSUE, S_STORE, S_REJECT, S_PRIV, S_HALT_IRQ: state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state != S_IDLE);
        done       = 1'b0;
        result_cc  = 2'd0;
        priv_fault = 1'b0;
        rd_valid   = 1'b0;
        sub_wr_en  = 1'b0;
        sts_wr_en  = 1'b0;
        cmd_valid  = 1'b0;
        halt_req   = 1'b0;
        chan_irq   = 1'b0;
        unique case (state)
            S_RD_REQ:   rd_valid = 1'b1;
            S_RD_WAIT:  sub_wr_en = rd_rvalid && !burst_q;
            S_ISSUE:    begin cmd_valid = 1'b1; done = 1'b1; result_cc = 2'd0; end
            S_STORE:    begin sts_wr_en = 1'b1; done = 1'b1; result_cc = 2'd1; end
            S_REJECT:   begin done = 1'b1; result_cc = cc_q; end
            S_PRIV:     begin priv_fault = 1'b1; done = 1'b1; end
            S_HALT:     halt_req = 1'b1;
            S_HALT_IRQ: begin chan_irq = 1'b1; done = 1'b1; end
            default: ;
        endcase
    end

    assign sub_wr_dev  = dev_q;
    assign sub_wr_sel  = (phase == PH_CCW);
    assign sub_wr_data = rd_rdata;
    assign sts_wr_chan = chan_q;
    assign sts_wr_byte = sts_q;
    assign cmd_chan    = chan_q;
    assign cmd_dev     = dev_q;
    assign cmd_word    = ccw_q;
    assign halt_chan   = chan_q;
    assign halt_dev    = dev_q;
    assign irq_chan    = chan_q;

    chio_addr_gen #(
        .AW(AW), .BASE_ADDR(BASE_ADDR), .WORD_BYTES(WORD_BYTES)
    ) u_addr (
        .phase   (phase),
        .ccw_ptr (ccw_ptr),
        .addr    (rd_addr)
    );

    chio_word_bank #(.AW(AW), .DW(DW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .phase   (phase),
        .to_mx   (burst_q),
        .data    (rd_rdata),
        .ccw_ptr (ccw_ptr),
        .ccw_q   (ccw_q),
        .mx_caw  (mx_caw),
        .mx_cba  (mx_cba),
        .mx_ccw  (mx_ccw)
    );

    AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R9
    AST_ONE_READ_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_ready |=> !rd_valid); // R9
    AST_STS_ON_CC1: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !req_halt && req_cc == 2'd1 |=> sts_wr_en && done && !rd_valid && !cmd_valid); // R5
    AST_REJECT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !req_halt && req_cc[1] |=> done && !cmd_valid && !sts_wr_en && result_cc == $past(req_cc)); // R6
    AST_HALT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req && !halt_ack |=> halt_req && !done && !rd_valid); // R7
    AST_HALT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req && halt_ack |=> chan_irq && done); // R7
    AST_PRIV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_halt && mode_bit |=> priv_fault && done && !halt_req); // R8
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy); // R10
    AST_DONE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R10

endmodule

// File: tb/chio_init_seq_tb.sv
module chio_init_seq_tb;
    localparam int CH_W = 4, DEV_W = 8, AW = 16, DW = 32, STS_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              req_valid = 0, req_halt = 0, req_burst = 0, req_blk = 0, mode_bit = 0;
    logic [CH_W-1:0]   req_chan = '0;
    logic [DEV_W-1:0]  req_dev = '0;
    logic [1:0]        req_cc = '0;
    logic [STS_W-1:0]  dev_status = '0;
    logic              busy, done, priv_fault, rd_valid, sub_wr_en, sub_wr_sel;
    logic [1:0]        result_cc;
    logic [AW-1:0]     rd_addr;
    logic              rd_ready = 0, rd_rvalid = 0;
    logic [DW-1:0]     rd_rdata = '0;
    logic [DEV_W-1:0]  sub_wr_dev, cmd_dev, halt_dev;
    logic [DW-1:0]     sub_wr_data, mx_caw, mx_cba, mx_ccw, cmd_word;
    logic              sts_wr_en, cmd_valid, halt_req, chan_irq;
    logic              halt_ack = 0;
    logic [CH_W-1:0]   sts_wr_chan, cmd_chan, halt_chan, irq_chan;
    logic [STS_W-1:0]  sts_wr_byte;

    chio_init_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_halt(req_halt),
        .req_chan(req_chan), .req_dev(req_dev), .req_cc(req_cc), .req_burst(req_burst),
        .req_blk(req_blk), .mode_bit(mode_bit), .dev_status(dev_status),
        .busy(busy), .done(done), .result_cc(result_cc), .priv_fault(priv_fault),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
        .sub_wr_en(sub_wr_en), .sub_wr_dev(sub_wr_dev), .sub_wr_sel(sub_wr_sel),
        .sub_wr_data(sub_wr_data), .mx_caw(mx_caw), .mx_cba(mx_cba), .mx_ccw(mx_ccw),
        .sts_wr_en(sts_wr_en), .sts_wr_chan(sts_wr_chan), .sts_wr_byte(sts_wr_byte),
        .cmd_valid(cmd_valid), .cmd_chan(cmd_chan), .cmd_dev(cmd_dev), .cmd_word(cmd_word),
        .halt_req(halt_req), .halt_chan(halt_chan), .halt_dev(halt_dev),
        .halt_ack(halt_ack), .chan_irq(chan_irq), .irq_chan(irq_chan)
    );

    int checks = 0, failures = 0;
    int cycles = 0;

    // memory model settings and content
    int rdy_delay = 0, rd_lat = 0, halt_delay = 0;
    logic [DW-1:0] caw_val = '0, cba_val = '0;

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        if (a == 16'd72) return caw_val;
        if (a == 16'd76) return cba_val;
        return 32'h5A5A_0000 ^ {16'h0, a};
    endfunction

    // monitor records
    int n_done, n_cmd, n_sts, n_sub, n_irq, n_priv, n_reads, n_busy, n_halt;
    logic [1:0]       last_res;
    logic [DW-1:0]    last_cmd_word;
    logic [CH_W-1:0]  last_cmd_chan, last_sts_chan, last_irq_chan, last_halt_chan;
    logic [DEV_W-1:0] last_cmd_dev, last_sub_dev;
    logic [STS_W-1:0] last_sts_byte;
    logic             sub_sel_log [4];
    logic [DW-1:0]    sub_dat_log [4];
    logic [AW-1:0]    rd_log [4];

    task automatic clear_mon();
        n_done = 0; n_cmd = 0; n_sts = 0; n_sub = 0; n_irq = 0; n_priv = 0;
        n_reads = 0; n_busy = 0; n_halt = 0;
    endtask

    // memory and device-control responders
    int rdly_cnt = 0, lat_cnt = 0, hcnt = 0;
    logic pend = 0;
    logic [AW-1:0] pend_addr = '0;
    always @(negedge clk) begin
        rd_ready  = 1'b0;
        rd_rvalid = 1'b0;
        halt_ack  = 1'b0;
        if (pend) begin
            if (lat_cnt == 0) begin
                rd_rvalid = 1'b1;
                rd_rdata  = mem_word(pend_addr);
                pend      = 1'b0;
            end else lat_cnt--;
        end else if (rd_valid) begin
            if (rdly_cnt < rdy_delay) rdly_cnt++;
            else begin
                rdly_cnt  = 0;
                rd_ready  = 1'b1;
                pend      = 1'b1;
                pend_addr = rd_addr;
                lat_cnt   = rd_lat;
                if (n_reads < 4) rd_log[n_reads] = rd_addr;
                n_reads++;
            end
        end
        if (halt_req) begin
            if (hcnt >= halt_delay) begin halt_ack = 1'b1; hcnt = 0; end
            else hcnt++;
        end
    end

    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (busy) n_busy++;
            if (done) begin n_done++; last_res = result_cc; end
            if (cmd_valid) begin
                n_cmd++; last_cmd_word = cmd_word; last_cmd_chan = cmd_chan; last_cmd_dev = cmd_dev;
            end
            if (sts_wr_en) begin n_sts++; last_sts_chan = sts_wr_chan; last_sts_byte = sts_wr_byte; end
            if (sub_wr_en) begin
                if (n_sub < 4) begin sub_sel_log[n_sub] = sub_wr_sel; sub_dat_log[n_sub] = sub_wr_data; end
                last_sub_dev = sub_wr_dev;
                n_sub++;
            end
            if (chan_irq) begin n_irq++; last_irq_chan = irq_chan; end
            if (priv_fault) n_priv++;
            if (halt_req) begin n_halt++; last_halt_chan = halt_chan; end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog act=%0d exp=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic run_req(input logic halt, input logic [CH_W-1:0] ch, input logic [DEV_W-1:0] dv,
                           input logic [1:0] cc, input logic bur, input logic blk,
                           input logic mb, input logic [STS_W-1:0] st);
        @(negedge clk);
        clear_mon();
        req_halt = halt; req_chan = ch; req_dev = dv; req_cc = cc;
        req_burst = bur; req_blk = blk; mode_bit = mb; dev_status = st;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        #2;
        while (n_done == 0) begin @(negedge clk); #2; end
        @(negedge clk); #2;
    endtask

    logic [DW-1:0] exp_caw = '0, exp_cba = '0, exp_ccw = '0;

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R1 reset state
        chk(!busy && !done && !rd_valid && !cmd_valid && !sts_wr_en && !sub_wr_en,
            "R1 strobes idle", {26'd0, busy, done, rd_valid, cmd_valid, sts_wr_en, sub_wr_en}, 0);
        chk(!halt_req && !chan_irq && !priv_fault, "R1 halt idle", {29'd0, halt_req, chan_irq, priv_fault}, 0);
        chk(mx_caw == 0 && mx_cba == 0 && mx_ccw == 0, "R1 mx regs", mx_caw | mx_cba | mx_ccw, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R4 R9 R10: sweep of code-0 starts
        for (int i = 0; i < 16; i++) begin
            logic bur, blk;
            logic [AW-1:0] ptr;
            logic [DW-1:0] ccw_v;
            int nr;
            bur = i[0]; blk = i[1];
            rdy_delay = i[2] ? 2 : 0;
            rd_lat    = i[3] ? 1 : 0;
            ptr     = 16'h0100 + 16'(i * 8);
            caw_val = {16'hCA00 + 16'(i), ptr};
            cba_val = 32'hB0B0_0000 + i;
            ccw_v   = 32'h5A5A_0000 ^ {16'h0, ptr};
            run_req(1'b0, 4'(i), 8'(8'h30 + i), 2'd0, bur, blk, 1'b0, 8'h00);
            nr = (bur && blk) ? 3 : 2;
            chk(n_reads == nr, "R2 R3 read count", n_reads, nr);
            chk(rd_log[0] == 16'd72, "R2 R3 caw addr", rd_log[0], 72);
            if (nr == 3) begin
                chk(rd_log[1] == 16'd76, "R2 cba addr", rd_log[1], 76);
                chk(rd_log[2] == ptr, "R2 ccw addr", rd_log[2], ptr);
            end else
                chk(rd_log[1] == ptr, "R2 R3 ccw addr", rd_log[1], ptr);
            if (bur) begin
                exp_caw = caw_val; exp_ccw = ccw_v;
                if (blk) exp_cba = cba_val;
                chk(n_sub == 0, "R2 no sub write", n_sub, 0);
            end else begin
                chk(n_sub == 2, "R3 sub writes", n_sub, 2);
                chk(sub_sel_log[0] == 0 && sub_dat_log[0] == caw_val, "R3 sub caw", sub_dat_log[0], caw_val);
                chk(sub_sel_log[1] == 1 && sub_dat_log[1] == ccw_v, "R3 sub ccw", sub_dat_log[1], ccw_v);
                chk(last_sub_dev == 8'(8'h30 + i), "R3 sub dev", last_sub_dev, 8'h30 + i);
            end
            chk(mx_caw == exp_caw, "R2 R3 mx_caw", mx_caw, exp_caw);
            chk(mx_cba == exp_cba, "R2 R3 mx_cba", mx_cba, exp_cba);
            chk(mx_ccw == exp_ccw, "R2 R3 mx_ccw", mx_ccw, exp_ccw);
            chk(n_cmd == 1 && last_cmd_word == ccw_v, "R4 cmd word", last_cmd_word, ccw_v);
            chk(last_cmd_chan == 4'(i) && last_cmd_dev == 8'(8'h30 + i), "R4 cmd target",
                {last_cmd_chan, last_cmd_dev}, {4'(i), 8'(8'h30 + i)});
            chk(last_res == 2'd0 && n_sts == 0, "R4 result", last_res, 0);
            chk(n_busy == nr * (rdy_delay + rd_lat + 2) + 1, "R9 R10 busy cycles",
                n_busy, nr * (rdy_delay + rd_lat + 2) + 1);
            chk(!busy, "R10 idle after", busy, 0);
        end

        // R5 R6: codes 1..3
        rdy_delay = 0; rd_lat = 0;
        for (int c = 1; c < 4; c++) begin
            for (int b = 0; b < 2; b++) begin
                run_req(1'b0, 4'(c + 8), 8'(c), 2'(c), b[0], 1'b1, 1'b0, 8'(8'hE0 + c));
                chk(n_reads == 0 && n_cmd == 0, "R5 R6 no fetch or cmd", n_reads + n_cmd, 0);
                chk(last_res == 2'(c), "R5 R6 result", last_res, c);
                chk(n_busy == 1, "R5 R6 one cycle", n_busy, 1);
                if (c == 1) begin
                    chk(n_sts == 1 && last_sts_chan == 4'(c + 8), "R5 status chan", last_sts_chan, c + 8);
                    chk(last_sts_byte == 8'(8'hE0 + c), "R5 status byte", last_sts_byte, 8'hE0 + c);
                end else
                    chk(n_sts == 0, "R6 no status", n_sts, 0);
            end
        end

        // R7: halts with several acknowledge delays
        for (int d = 0; d < 4; d++) begin
            halt_delay = d;
            run_req(1'b1, 4'(d + 3), 8'h77, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00);
            chk(n_halt == d + 1 && last_halt_chan == 4'(d + 3), "R7 halt held", n_halt, d + 1);
            chk(n_irq == 1 && last_irq_chan == 4'(d + 3), "R7 irq", {n_irq[3:0], last_irq_chan}, {4'd1, 4'(d + 3)});
            chk(n_reads == 0 && n_cmd == 0 && n_priv == 0, "R7 no fetch", n_reads + n_cmd + n_priv, 0);
            chk(n_busy == d + 2, "R7 R10 busy cycles", n_busy, d + 2);
        end

        // R8: halt in problem state
        run_req(1'b1, 4'd5, 8'h12, 2'd0, 1'b0, 1'b0, 1'b1, 8'h00);
        chk(n_priv == 1 && n_halt == 0 && n_irq == 0, "R8 priv fault", {n_priv[3:0], n_halt[3:0]}, 8'h10);
        chk(n_busy == 1, "R8 one cycle", n_busy, 1);

        // R10: request while busy is ignored
        halt_delay = 5;
        @(negedge clk);
        clear_mon();
        req_halt = 1'b1; req_chan = 4'd2; mode_bit = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_halt = 1'b0; req_cc = 2'd1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        #2;
        while (n_done == 0) begin @(negedge clk); #2; end
        repeat (3) @(negedge clk);
        #2;
        chk(n_done == 1 && n_sts == 0, "R10 busy request dropped", {n_done[3:0], n_sts[3:0]}, 8'h10);
        chk(n_irq == 1 && !busy, "R10 halt completed", {n_irq[3:0], 3'd0, busy}, 8'h10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule